// File: doc/BRIEF.md
# Eligibility-Filtered Ordered Scheduling List

This block keeps a small set of scheduling entries in rank order. Each entry holds a flow identifier, a 16-bit rank and a 16-bit eligibility time. A scheduler can do three things with it. It can insert an entry at the place its rank calls for. It can pull out the lowest-ranked entry whose eligibility time has been reached. It can pull out one flow by its identifier. The time used in the eligibility test comes in on a port. The same list can therefore hold back entries against wall-clock time or against a virtual clock. For example, with the start time as eligibility and the finish time as rank, the list applies a worst-case fair weighted queueing order.

Commands arrive on a valid/ready port that carries an opcode and operands. Each accepted command takes exactly four clock edges. The count is the same at any occupancy. A one-cycle response then reports the removed entry, or flags a miss or an overflow. The list is held in registers and every slot is compared in parallel. This suits list depths of a few tens of entries.

Top module: `elig_order_list`

## Requirements
- R1: After reset, cmd_ready is high, rsp_valid is low and the list is empty, so a dequeue returns rsp_miss = 1.
- R2: Enqueue (cmd_op = 2'b00) places the entry so that the list stays in non-decreasing rank order, and its response echoes the enqueued flow and rank with both flags low.
- R3: Enqueue while all N slots are occupied returns rsp_ovf = 1 and leaves the stored entries and their order unchanged.
- R4: Dequeue (cmd_op = 2'b01) returns and removes the lowest-ranked entry whose eligibility time is less than or equal to cur_time, compared unsigned. Lower-ranked entries that are not yet eligible are skipped.
- R5: Among eligible entries of equal rank, dequeue returns the one that was enqueued first.
- R6: A dequeue that finds no eligible entry (including on an empty list), and any command with cmd_op = 2'b11, returns rsp_miss = 1 and does not change the list.
- R7: Dequeue-by-id (cmd_op = 2'b10) removes and returns the first stored entry whose flow equals cmd_flow, whatever its rank or eligibility. An absent flow returns rsp_miss = 1 and leaves the list unchanged.
- R8: A command accepted on one clock edge gives a one-cycle rsp_valid pulse after the fourth edge, counting the accepting edge as the first. cmd_ready is low from the accepting edge until that response.
- R9: After any removal the remaining entries close the gap and stay contiguous and sorted, so later commands see the same order minus the removed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 00 enqueue, 01 dequeue eligible, 10 dequeue by flow id, 11 no operation |
| cmd_flow | input | FLOW_W | Flow identifier for enqueue or dequeue-by-id |
| cmd_rank | input | KEY_W | Rank for enqueue |
| cmd_elig | input | KEY_W | Eligibility time for enqueue |
| cur_time | input | KEY_W | Time compared against eligibility, captured with the command |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_flow | output | FLOW_W | Removed or enqueued flow |
| rsp_rank | output | KEY_W | Removed or enqueued rank |
| rsp_elig | output | KEY_W | Removed or enqueued eligibility time |
| rsp_miss | output | 1 | No eligible entry, flow not found, or no-operation |
| rsp_ovf | output | 1 | Enqueue rejected because the list is full |

## Verification
The properties assume that cmd_valid is low while the internal reset is still held. They also assume that a command is presented only when cmd_ready is high, so that nothing is accepted during the four-edge window. The bench drives commands strictly one at a time. It waits for each response before driving the next command, and it holds cmd_valid low for several cycles after reset is released. Time values in the stimulus stay within the unsigned 16-bit range and never rely on wrap-around.

// File: rtl/elig_order_pkg.sv
`timescale 1ns/1ps
package elig_order_pkg;
  typedef enum logic [1:0] {
    OP_ENQ    = 2'b00,
    OP_DEQ    = 2'b01,
    OP_DEQ_ID = 2'b10,
    OP_NOP    = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_MATCH  = 2'b01,
    PH_PICK   = 2'b10,
    PH_COMMIT = 2'b11
  } phase_e;
endpackage

// File: rtl/eol_cmp_bank.sv
`timescale 1ns/1ps
module eol_cmp_bank #(
  parameter int N      = 8,
  parameter int FLOW_W = 8,
  parameter int KEY_W  = 16,
  localparam int CW    = $clog2(N + 1)
) (
  input  logic [N-1:0][FLOW_W-1:0] ent_flow,
  input  logic [N-1:0][KEY_W-1:0]  ent_rank,
  input  logic [N-1:0][KEY_W-1:0]  ent_elig,
  input  logic [CW-1:0]            ent_cnt,
  input  logic [FLOW_W-1:0]        key_flow,
  input  logic [KEY_W-1:0]         key_rank,
  input  logic [KEY_W-1:0]         now,
  output logic [N-1:0]             elig_m,
  output logic [N-1:0]             id_m,
  output logic [N-1:0]             gt_m
);
  // one comparator set per slot, all evaluated in parallel
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic live;
    assign live      = CW'(i) < ent_cnt;
    assign elig_m[i] = live && (ent_elig[i] <= now);
    assign id_m[i]   = live && (ent_flow[i] == key_flow);
    assign gt_m[i]   = live && (ent_rank[i] > key_rank);
  end
endmodule

// File: rtl/eol_first_one.sv
`timescale 1ns/1ps
module eol_first_one #(
  parameter int W   = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  // lowest set bit wins: head of the list has priority
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/eol_store.sv
`timescale 1ns/1ps
module eol_store #(
  parameter int N      = 8,
  parameter int FLOW_W = 8,
  parameter int KEY_W  = 16,
  localparam int CW    = $clog2(N + 1),
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_en,
  input  logic                     rem_en,
  input  logic [IW-1:0]            pos,
  input  logic [FLOW_W-1:0]        new_flow,
  input  logic [KEY_W-1:0]         new_rank,
  input  logic [KEY_W-1:0]         new_elig,
  output logic [N-1:0][FLOW_W-1:0] ent_flow,
  output logic [N-1:0][KEY_W-1:0]  ent_rank,
  output logic [N-1:0][KEY_W-1:0]  ent_elig,
  output logic [CW-1:0]            ent_cnt
);
  logic [N-1:0][FLOW_W-1:0] nxt_flow;
  logic [N-1:0][KEY_W-1:0]  nxt_rank;
  logic [N-1:0][KEY_W-1:0]  nxt_elig;
  logic [CW-1:0]            nxt_cnt;
  logic                     upd_en;

  assign upd_en = ins_en || rem_en;

  always_comb begin
    nxt_flow = ent_flow;
    nxt_rank = ent_rank;
    nxt_elig = ent_elig;
    nxt_cnt  = ent_cnt;
    if (ins_en) begin
      // open a hole at pos by moving the tail one slot down
      for (int i = 1; i < N; i++) begin
        if (IW'(i) > pos) begin
          nxt_flow[i] = ent_flow[i-1];
          nxt_rank[i] = ent_rank[i-1];
          nxt_elig[i] = ent_elig[i-1];
        end
      end
      nxt_flow[pos] = new_flow;
      nxt_rank[pos] = new_rank;
      nxt_elig[pos] = new_elig;
      nxt_cnt       = ent_cnt + 1'b1;
    end else if (rem_en) begin
      // close the gap at pos by moving the tail one slot up
      for (int i = 0; i < N - 1; i++) begin
        if (IW'(i) >= pos) begin
          nxt_flow[i] = ent_flow[i+1];
          nxt_rank[i] = ent_rank[i+1];
          nxt_elig[i] = ent_elig[i+1];
        end
      end
      nxt_cnt = ent_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_cnt <= '0;
    end else if (upd_en) begin
      ent_cnt <= nxt_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      ent_flow <= nxt_flow;
      ent_rank <= nxt_rank;
      ent_elig <= nxt_elig;
    end
  end
endmodule

// File: rtl/elig_order_list.sv
`timescale 1ns/1ps
module elig_order_list
  import elig_order_pkg::*;
#(
  parameter int N      = 8,
  parameter int FLOW_W = 8,
  parameter int KEY_W  = 16,
  localparam int CW    = $clog2(N + 1),
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [FLOW_W-1:0] cmd_flow,
  input  logic [KEY_W-1:0]  cmd_rank,
  input  logic [KEY_W-1:0]  cmd_elig,
  input  logic [KEY_W-1:0]  cur_time,
  output logic              rsp_valid,
  output logic [FLOW_W-1:0] rsp_flow,
  output logic [KEY_W-1:0]  rsp_rank,
  output logic [KEY_W-1:0]  rsp_elig,
  output logic              rsp_miss,
  output logic              rsp_ovf
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  phase_e ph_q, ph_d;
  logic   accept;

  assign cmd_ready = (ph_q == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (accept) ph_d = PH_MATCH;
      PH_MATCH:  ph_d = PH_PICK;
      PH_PICK:   ph_d = PH_COMMIT;
      PH_COMMIT: ph_d = PH_IDLE;
    endcase
  end

  // captured command
  op_e               op_q;
  logic [FLOW_W-1:0] kflow_q;
  logic [KEY_W-1:0]  krank_q, kelig_q, now_q;

  // list state
  logic [N-1:0][FLOW_W-1:0] st_flow;
  logic [N-1:0][KEY_W-1:0]  st_rank, st_elig;
  logic [CW-1:0]            st_cnt;

  // match stage
  logic [N-1:0] elig_m, id_m, gt_m;
  logic [N-1:0] elig_m_q, id_m_q, gt_m_q;

  eol_cmp_bank #(.N(N), .FLOW_W(FLOW_W), .KEY_W(KEY_W)) cmp_i (
    .ent_flow (st_flow),
    .ent_rank (st_rank),
    .ent_elig (st_elig),
    .ent_cnt  (st_cnt),
    .key_flow (kflow_q),
    .key_rank (krank_q),
    .now      (now_q),
    .elig_m   (elig_m),
    .id_m     (id_m),
    .gt_m     (gt_m)
  );

  // pick stage
  logic [N-1:0]  sel_m;
  logic [IW-1:0] first_idx, pick_idx_d, pick_idx_q;
  logic          first_hit, pick_hit_q;

  always_comb begin
    unique case (op_q)
      OP_DEQ:    sel_m = elig_m_q;
      OP_DEQ_ID: sel_m = id_m_q;
      default:   sel_m = gt_m_q;
    endcase
  end

  eol_first_one #(.W(N)) first_i (
    .vec   (sel_m),
    .idx   (first_idx),
    .found (first_hit)
  );

  // enqueue with no larger rank stored goes to the tail
  assign pick_idx_d = (op_q == OP_ENQ && !first_hit) ? IW'(st_cnt) : first_idx;

  // commit stage
  logic is_commit, full, is_rem_op, ins_en, rem_en;

  assign is_commit = (ph_q == PH_COMMIT);
  assign full      = (st_cnt == CW'(N));
  assign is_rem_op = (op_q == OP_DEQ) || (op_q == OP_DEQ_ID);
  assign ins_en    = is_commit && (op_q == OP_ENQ) && !full;
  assign rem_en    = is_commit && is_rem_op && pick_hit_q;

  eol_store #(.N(N), .FLOW_W(FLOW_W), .KEY_W(KEY_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ins_en   (ins_en),
    .rem_en   (rem_en),
    .pos      (pick_idx_q),
    .new_flow (kflow_q),
    .new_rank (krank_q),
    .new_elig (kelig_q),
    .ent_flow (st_flow),
    .ent_rank (st_rank),
    .ent_elig (st_elig),
    .ent_cnt  (st_cnt)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ph_q      <= PH_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      rsp_valid <= is_commit;
    end
  end

  // datapath registers, each with its own enable
  always_ff @(posedge clk) begin
    if (accept) begin
      op_q    <= op_e'(cmd_op);
      kflow_q <= cmd_flow;
      krank_q <= cmd_rank;
      kelig_q <= cmd_elig;
      now_q   <= cur_time;
    end
    if (ph_q == PH_MATCH) begin
      elig_m_q <= elig_m;
      id_m_q   <= id_m;
      gt_m_q   <= gt_m;
    end
    if (ph_q == PH_PICK) begin
      pick_idx_q <= pick_idx_d;
      pick_hit_q <= first_hit;
    end
    if (is_commit) begin
      rsp_miss <= (is_rem_op && !pick_hit_q) || (op_q == OP_NOP);
      rsp_ovf  <= (op_q == OP_ENQ) && full;
      if (op_q == OP_ENQ) begin
        rsp_flow <= kflow_q;
        rsp_rank <= krank_q;
        rsp_elig <= kelig_q;
      end else begin
        rsp_flow <= st_flow[pick_idx_q];
        rsp_rank <= st_rank[pick_idx_q];
        rsp_elig <= st_elig[pick_idx_q];
      end
    end
  end
endmodule

// File: rtl/elig_order_list_chk.sv
`timescale 1ns/1ps
module elig_order_list_chk #(
  parameter int N      = 8,
  parameter int KEY_W  = 16,
  localparam int CW    = $clog2(N + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic                    rsp_valid,
  input logic                    rsp_miss,
  input logic                    rsp_ovf,
  input logic [CW-1:0]           ent_cnt,
  input logic [N-1:0][KEY_W-1:0] ent_rank
);
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_resp_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && cmd_ready, 4));

  p_resp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ovf) |-> (ent_cnt == CW'(N) && !rsp_miss));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ent_cnt <= CW'(N));

  p_miss_keeps_list_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (ent_cnt == $past(ent_cnt)));

  for (genvar i = 0; i < N - 1; i++) begin : g_ord
    p_sorted_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(i + 1) < ent_cnt) |-> (ent_rank[i] <= ent_rank[i+1]));
  end
endmodule

bind elig_order_list elig_order_list_chk #(.N(N), .KEY_W(KEY_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .rsp_miss  (rsp_miss),
  .rsp_ovf   (rsp_ovf),
  .ent_cnt   (st_cnt),
  .ent_rank  (st_rank)
);

// File: tb/elig_order_list_tb.sv
`timescale 1ns/1ps
module elig_order_list_tb_top;
  localparam int N      = 8;
  localparam int FLOW_W = 8;
  localparam int KEY_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [1:0]        cmd_op;
  logic [FLOW_W-1:0] cmd_flow;
  logic [KEY_W-1:0]  cmd_rank, cmd_elig, cur_time;
  logic              rsp_valid;
  logic [FLOW_W-1:0] rsp_flow;
  logic [KEY_W-1:0]  rsp_rank, rsp_elig;
  logic              rsp_miss, rsp_ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  elig_order_list #(.N(N), .FLOW_W(FLOW_W), .KEY_W(KEY_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_flow(cmd_flow), .cmd_rank(cmd_rank), .cmd_elig(cmd_elig),
    .cur_time(cur_time),
    .rsp_valid(rsp_valid), .rsp_flow(rsp_flow), .rsp_rank(rsp_rank),
    .rsp_elig(rsp_elig), .rsp_miss(rsp_miss), .rsp_ovf(rsp_ovf)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  flow;
    logic [15:0] rank;
    logic [15:0] elig;
    logic [15:0] now;
    logic        miss;
    logic        ovf;
    logic [7:0]  xflow;
    logic [15:0] xrank;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd1, 16'd10, 16'd16, 16'd0,     1'b0, 1'b0, 8'd1, 16'd10},
    '{2'd0, 8'd2, 16'd12, 16'd9,  16'd0,     1'b0, 1'b0, 8'd2, 16'd12},
    '{2'd0, 8'd3, 16'd4,  16'd16, 16'd0,     1'b0, 1'b0, 8'd3, 16'd4},
    '{2'd0, 8'd4, 16'd13, 16'd4,  16'd0,     1'b0, 1'b0, 8'd4, 16'd13},
    '{2'd0, 8'd5, 16'd19, 16'd6,  16'd0,     1'b0, 1'b0, 8'd5, 16'd19},
    '{2'd0, 8'd6, 16'd13, 16'd2,  16'd0,     1'b0, 1'b0, 8'd6, 16'd13},
    '{2'd1, 8'd0, 16'd0,  16'd0,  16'd7,     1'b0, 1'b0, 8'd4, 16'd13},
    '{2'd1, 8'd0, 16'd0,  16'd0,  16'd7,     1'b0, 1'b0, 8'd6, 16'd13},
    '{2'd1, 8'd0, 16'd0,  16'd0,  16'd7,     1'b0, 1'b0, 8'd5, 16'd19},
    '{2'd1, 8'd0, 16'd0,  16'd0,  16'd7,     1'b1, 1'b0, 8'd0, 16'd0},
    '{2'd1, 8'd0, 16'd0,  16'd0,  16'd9,     1'b0, 1'b0, 8'd2, 16'd12},
    '{2'd2, 8'd3, 16'd0,  16'd0,  16'd0,     1'b0, 1'b0, 8'd3, 16'd4},
    '{2'd2, 8'd9, 16'd0,  16'd0,  16'd0,     1'b1, 1'b0, 8'd0, 16'd0},
    '{2'd1, 8'd0, 16'd0,  16'd0,  16'd15,    1'b1, 1'b0, 8'd0, 16'd0},
    '{2'd3, 8'd1, 16'd0,  16'd0,  16'd65535, 1'b1, 1'b0, 8'd0, 16'd0},
    '{2'd1, 8'd0, 16'd0,  16'd0,  16'd16,    1'b0, 1'b0, 8'd1, 16'd10},
    '{2'd1, 8'd0, 16'd0,  16'd0,  16'd65535, 1'b1, 1'b0, 8'd0, 16'd0}
  };
  localparam string VTAG [NV] = '{
    "R2", "R2", "R2", "R2", "R2", "R2",
    "R5", "R5", "R4", "R6", "R4", "R7", "R7", "R9", "R6", "R4", "R6"
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // issue one command, check R8 timing, then the response fields
  task automatic run(input logic [1:0] op, input logic [7:0] flow,
                     input logic [15:0] rank, input logic [15:0] elig,
                     input logic [15:0] now, input logic x_miss,
                     input logic x_ovf, input logic [7:0] x_flow,
                     input logic [15:0] x_rank, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_flow = flow;
    cmd_rank = rank; cmd_elig = elig; cur_time = now;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      check("R8", "ready low while busy", 32'(cmd_ready), 32'd0);
      check("R8", "no early response", 32'(rsp_valid), 32'd0);
      @(negedge clk);
    end
    check("R8", "response after four edges", 32'(rsp_valid), 32'd1);
    check(tag, "miss flag", 32'(rsp_miss), 32'(x_miss));
    check(tag, "overflow flag", 32'(rsp_ovf), 32'(x_ovf));
    if (!x_miss && !x_ovf) begin
      check(tag, "flow", 32'(rsp_flow), 32'(x_flow));
      check(tag, "rank", 32'(rsp_rank), 32'(x_rank));
    end
    @(negedge clk);
    check("R8", "single-cycle response", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_flow = '0;
    cmd_rank = '0; cmd_elig = '0; cur_time = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, then an empty dequeue misses
    check("R1", "ready after reset", 32'(cmd_ready), 32'd1);
    check("R1", "no response after reset", 32'(rsp_valid), 32'd0);
    run(2'd1, 8'd0, 16'd0, 16'd0, 16'd65535, 1'b1, 1'b0, 8'd0, 16'd0, "R1");

    // table walk
    for (int v = 0; v < NV; v++) begin
      run(VECS[v].op, VECS[v].flow, VECS[v].rank, VECS[v].elig, VECS[v].now,
          VECS[v].miss, VECS[v].ovf, VECS[v].xflow, VECS[v].xrank, VTAG[v]);
    end

    // R3: fill with scrambled ranks, overflow attempt, then drain in order (R2, R9)
    for (int i = 0; i < N; i++) begin
      run(2'd0, 8'(100 + i), 16'(((i * 5) % 8) * 10 + 1), 16'd0, 16'd0,
          1'b0, 1'b0, 8'(100 + i), 16'(((i * 5) % 8) * 10 + 1), "R2");
    end
    run(2'd0, 8'd200, 16'd0, 16'd0, 16'd0, 1'b0, 1'b1, 8'd0, 16'd0, "R3");
    run(2'd2, 8'd200, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 8'd0, 16'd0, "R3");
    // R7: take one from the middle by id, regardless of its rank
    run(2'd2, 8'd104, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 8'd104, 16'd41, "R7");
    for (int k = 0; k < N; k++) begin
      if (k != 4) begin
        run(2'd1, 8'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0,
            8'(100 + ((k * 5) % 8)), 16'(k * 10 + 1), "R9");
      end
    end
    run(2'd1, 8'd0, 16'd0, 16'd0, 16'd65535, 1'b1, 1'b0, 8'd0, 16'd0, "R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule